// File: doc/BRIEF.md
# Pseudo-Random Logic Self-Test Engine

This block tests a piece of logic on the chip with no tester attached. A start pulse launches a run. For a fixed number of cycles, the engine drives the circuit under test with patterns from a 16-bit linear feedback shift register. The seed and the feedback tap mask are inputs. Every response that comes back in the same cycle is folded into a 16-bit signature register. When the run is over, the signature is compared with a golden value and the single-bit result is held until the next start.

A pattern-generation FSM owns the shift register and the pattern count. A compaction FSM clears the signature, accumulates it and performs the final compare. Outside a run, a data mux passes functional data to the circuit under test. Because start is an ordinary level-sampled input, the same sequence can be fired by power-on logic after every reset.

Top module: `lbist_engine`

## Requirements
- R1: After reset, done and okay are 0 and `cut_in` equals `func_data`.
- R2: Whenever no run is in progress, `cut_in` equals `func_data` in the same cycle.
- R3: A start accepted at a clock edge makes the first pattern on `cut_in` after that edge equal to `seed`. A seed of zero is replaced by the value 1.
- R4: Each following pattern p' is derived from the previous pattern p as p' = {p[14:0], parity(p & taps)}. Bit 0 takes the feedback.
- R5: Exactly NPAT patterns are driven, one per cycle. In the next cycle, `cut_in` returns to `func_data`.
- R6: The signature is cleared at start. In each pattern cycle it becomes s' = {s[14:0], parity(s & taps)} XOR `cut_resp`, using the response present in that cycle.
- R7: done rises two cycles after the last pattern cycle. In that same cycle, okay shows whether the final signature equals `golden_sig`.
- R8: okay is 0 whenever done is 0, and done is 0 throughout a run.
- R9: A start raised while a run or its compare is in progress is ignored, and the pattern sequence continues unchanged.
- R10: A start raised after done clears done and okay and begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a self-test run |
| seed | input | 16 | Initial shift-register state |
| taps | input | 16 | Feedback tap mask for generator and signature |
| func_data | input | 16 | Functional data for the circuit under test |
| cut_resp | input | 16 | Response of the circuit under test |
| golden_sig | input | 16 | Expected final signature |
| cut_in | output | 16 | Muxed data to the circuit under test |
| done | output | 1 | Run finished; result valid |
| okay | output | 1 | Signature matched the golden value |

## Verification
The first pattern appears one cycle after the edge that accepts start. Each later pattern follows one cycle after the one before it. The bench drives at the falling edge and compares `cut_in` there against its own shift-register model, then supplies the response that the signature absorbs at the next rising edge. The mux returns to functional data one cycle after the last pattern. done and okay are due one cycle after that, and the bench checks each of these cycles separately, including a start pulse injected in the middle of a run.

// File: rtl/lbist_engine.sv
module lbist_engine #(
  parameter int W    = 16,
  parameter int NPAT = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] seed,
  input  logic [W-1:0] taps,
  input  logic [W-1:0] func_data,
  input  logic [W-1:0] cut_resp,
  input  logic [W-1:0] golden_sig,
  output logic [W-1:0] cut_in,
  output logic         done,
  output logic         okay
);
  localparam int CW = $clog2(NPAT + 1);

  typedef enum logic {G_IDLE, G_RUN} gen_t;
  typedef enum logic [1:0] {C_IDLE, C_ACC, C_CMP, C_FIN} cmp_t;

  gen_t          gen_q;
  cmp_t          cmp_q;
  logic [W-1:0]  lfsr_q, sig_q;
  logic [CW-1:0] cnt_q;
  logic          busy, go, last;

  assign busy   = (gen_q == G_RUN) || (cmp_q == C_CMP);
  assign go     = start && !busy;
  assign last   = (gen_q == G_RUN) && (cnt_q == CW'(NPAT - 1));
  assign cut_in = (gen_q == G_RUN) ? lfsr_q : func_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q  <= G_IDLE;
      lfsr_q <= '0;
      cnt_q  <= '0;
    end else if (go) begin
      gen_q  <= G_RUN;
      lfsr_q <= (seed == '0) ? W'(1) : seed;
      cnt_q  <= '0;
    end else if (gen_q == G_RUN) begin
      lfsr_q <= {lfsr_q[W-2:0], ^(lfsr_q & taps)};
      cnt_q  <= cnt_q + 1'b1;
      if (last) gen_q <= G_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= C_IDLE;
      sig_q <= '0;
      done  <= 1'b0;
      okay  <= 1'b0;
    end else if (go) begin
      cmp_q <= C_ACC;
      sig_q <= '0;
      done  <= 1'b0;
      okay  <= 1'b0;
    end else begin
      case (cmp_q)
        C_ACC: begin
          sig_q <= {sig_q[W-2:0], ^(sig_q & taps)} ^ cut_resp;
          if (last) cmp_q <= C_CMP;
        end
        C_CMP: begin
          done  <= 1'b1;
          okay  <= (sig_q == golden_sig);
          cmp_q <= C_FIN;
        end
        default: ;
      endcase
    end
  end

  // R8
  okay_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    okay |-> done);

  // R8
  no_done_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_q == G_RUN) |-> !done);

  // R3
  seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> cut_in == (($past(seed) == '0) ? W'(1) : $past(seed)));

  // R4
  pattern_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((gen_q == G_RUN) && $past(gen_q == G_RUN) && !$past(go)) |->
      cut_in == {$past(cut_in[W-2:0]), ^($past(cut_in) & $past(taps))});
endmodule

// File: tb/lbist_engine_test.sv
module lbist_engine_test;
  localparam int W = 16;
  localparam int NPAT = 32;

  logic clk = 0, rst_n = 0, start = 0;
  logic [W-1:0] seed = 0, taps = 0, func_data = 0, cut_resp = 0, golden_sig = 0;
  logic [W-1:0] cut_in;
  logic done, okay;
  int total = 0, bad = 0;

  lbist_engine #(.W(W), .NPAT(NPAT)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .seed(seed), .taps(taps),
    .func_data(func_data), .cut_resp(cut_resp), .golden_sig(golden_sig),
    .cut_in(cut_in), .done(done), .okay(okay));

  always #2 clk = ~clk;

  function automatic logic [W-1:0] step(logic [W-1:0] v, logic [W-1:0] t);
    return {v[W-2:0], ^(v & t)};
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(logic [W-1:0] sd, logic [W-1:0] tp, bit good, bit poke);
    logic [W-1:0] resp [NPAT];
    logic [W-1:0] sig = '0, p;
    for (int i = 0; i < NPAT; i++) begin
      resp[i] = W'($urandom);
      sig = step(sig, tp) ^ resp[i];
    end
    @(negedge clk);
    seed = sd; taps = tp; start = 1;
    golden_sig = good ? sig : sig ^ W'(16'h0100);
    p = (sd == '0) ? W'(1) : sd;
    for (int k = 0; k < NPAT; k++) begin
      @(negedge clk);
      start = (poke && k == 5);
      func_data = W'($urandom);
      chk(k == 0 ? "R3" : (poke && k > 5 ? "R9" : "R4"), cut_in, p);
      chk("R8", {15'd0, done | okay}, '0);
      cut_resp = resp[k];
      p = step(p, tp);
    end
    @(negedge clk);
    start = 0;
    chk("R5", cut_in, func_data);
    chk("R7", {15'd0, done}, '0);
    @(negedge clk);
    chk("R7", {15'd0, done}, 16'd1);
    chk("R6", {15'd0, okay}, {15'd0, good});
    func_data = W'($urandom);
    #0 chk("R2", cut_in, func_data);
  endtask

  initial begin
    func_data = 16'h1234;
    #1 chk("R1", {14'd0, done, okay}, '0);
    chk("R1", cut_in, 16'h1234);
    #10 rst_n = 1;
    void'($urandom(7));
    run(16'hACE1, 16'hB400, 1, 0);
    run(16'h0000, 16'hD008, 0, 0);
    run(16'h8001, 16'h002D, 1, 1);
    for (int i = 0; i < 4; i++)
      run(W'($urandom), W'($urandom), i[0], 0);
    @(negedge clk);
    start = 1; seed = 16'h0042; taps = 16'h6000;
    @(negedge clk);
    start = 0;
    chk("R10", {14'd0, done, okay}, '0);
    chk("R10", cut_in, 16'h0042);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule